// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block collects interrupt sources for a small peripheral into one flag register and one enable register, each holding seven bits, and drives a single level interrupt request to the processor. Each flag bit is either event-type or level-type, fixed by a parameter mask. Event-type bits latch a one-cycle set pulse from a neighbouring unit such as a timer, a shift engine or an edge detector. They stay set until software clears them, or until another block asks for a clear as a side effect of a read it decoded, for example a counter-low or shift-data read. Level-type bits simply follow their external input.

Software reaches both registers through an 8-bit register port with separate read and write strobes. Writes to the enable register use bit 7 as a mode selector: one sets the bits marked by ones in the data, zero clears them. Writes to the flag register clear the bits written as ones. Reading the flag register returns a summary bit in bit 7 telling whether any enabled flag is pending. The interrupt request is a registered output and follows the registers one cycle later.

Top module: `evirq_ctrl`

## Requirements
- R1: A synchronous reset clears all flag bits and enable bits and deasserts `irq`; after reset an enable read returns 0x80 and a flag read returns 0x00.
- R2: `irq` is registered: it is high in the cycle after one in which (flag AND enable) is nonzero, and low in the cycle after one in which it is zero.
- R3: A write to the enable address (default 0xE) with data bit 7 = 1 sets each enable bit whose data bit (6..0) is 1 and leaves the other enable bits unchanged.
- R4: A write to the enable address with data bit 7 = 0 clears each enable bit whose data bit (6..0) is 1 and leaves the other enable bits unchanged.
- R5: A read of the enable address returns the enable bits in bits 6..0 with bit 7 always 1.
- R6: A read of the flag address (default 0xD) returns the flag bits in bits 6..0 and, in bit 7, 1 exactly when some flag bit and the same enable bit are both 1.
- R7: A write to the flag address clears every event-type flag bit whose data bit is 1; data bits of 0 change nothing.
- R8: A high `set_pulse[i]` for one cycle sets event-type flag bit i; pulses on level-type bits (default mask 0x03, bits 0 and 1) have no effect.
- R9: A level-type flag bit equals its `lvl_in` bit one cycle later; a flag write or clear request does not clear it while the input stays high.
- R10: A high `clr_req[i]` from another block clears event-type flag bit i.
- R11: When a set pulse and a clear (flag write or `clr_req`) hit the same event-type bit in the same cycle, the bit ends up set.
- R12: `rdata` is registered: it changes only at the clock edge where `rd_en` is high and then holds; reads of any address other than flag or enable return 0x00, and writes to such addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (4) | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Registered read data |
| set_pulse | input | DATA_W-1 (7) | Per-bit event set pulses |
| clr_req | input | DATA_W-1 (7) | Per-bit clear requests from neighbouring read decoders |
| lvl_in | input | DATA_W-1 (7) | Per-bit level inputs for level-type bits |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The hardest situation to reach is a collision in one cycle: a set pulse, a software flag write and a clear request from a neighbour all aimed at the same bit, with the outcome visible only after a later read. The stimulus drives all three on one bit within a single cycle and then reads the flag register back. A second hard case is the one-cycle gap between an enable write taking effect and `irq` rising. It is caught by sampling `irq` both in the cycle right after the write edge and in the cycle after that.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned SRC_N = BUS_W - 1;

  typedef enum logic {
    EN_MODE_CLEAR = 1'b0,
    EN_MODE_SET   = 1'b1
  } en_mode_e;
endpackage

// File: rtl/evirq_flag_bit.sv
module evirq_flag_bit #(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic lvl_i,
  output logic q_o
);
  logic q_q;
  logic q_d;

  // set has priority over clear so an event arriving with a clear is kept
  always_comb begin
    if (IS_LEVEL) q_d = lvl_i;
    else          q_d = set_i | (q_q & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) q_q <= 1'b0;
    else     q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/evirq_enable_reg.sv
module evirq_enable_reg
  import evirq_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  en_mode_e     mode_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_i) begin
      if (mode_i == EN_MODE_SET) en_q <= en_q | mask_i;
      else                       en_q <= en_q & ~mask_i;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/evirq_readback.sv
module evirq_readback #(
  parameter int unsigned N         = 7,
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hD,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'hE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      flag_i,
  input  logic [N-1:0]      en_i,
  output logic [N:0]        rdata_o
);
  logic [N:0] rdata_q;
  logic [N:0] sel_d;
  logic       pending;

  assign pending = |(flag_i & en_i);

  always_comb begin
    if (addr_i == FLAG_ADDR)    sel_d = {pending, flag_i};
    else if (addr_i == EN_ADDR) sel_d = {1'b1, en_i};
    else                        sel_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= sel_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/evirq_irq_reg.sv
module evirq_irq_reg #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl
  import evirq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hD,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'hE,
  parameter logic [DATA_W-2:0] LEVEL_MASK = 'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-2:0] set_pulse,
  input  logic [DATA_W-2:0] clr_req,
  input  logic [DATA_W-2:0] lvl_in,
  output logic              irq
);
  localparam int unsigned N = DATA_W - 1;

  logic [N-1:0] flag_q;
  logic [N-1:0] en_q;
  logic [N-1:0] clr_vec;
  logic         wr_flag;
  logic         wr_enable;
  en_mode_e     en_mode;

  assign wr_flag   = wr_en && (addr == FLAG_ADDR);
  assign wr_enable = wr_en && (addr == EN_ADDR);
  assign en_mode   = en_mode_e'(wdata[DATA_W-1]);
  assign clr_vec   = (wr_flag ? wdata[N-1:0] : '0) | clr_req;

  for (genvar i = 0; i < N; i++) begin : g_flag
    evirq_flag_bit #(
      .IS_LEVEL(LEVEL_MASK[i])
    ) u_bit (
      .clk  (clk),
      .rst  (rst),
      .set_i(set_pulse[i]),
      .clr_i(clr_vec[i]),
      .lvl_i(lvl_in[i]),
      .q_o  (flag_q[i])
    );
  end

  evirq_enable_reg #(.N(N)) u_en (
    .clk   (clk),
    .rst   (rst),
    .wr_i  (wr_enable),
    .mode_i(en_mode),
    .mask_i(wdata[N-1:0]),
    .en_o  (en_q)
  );

  evirq_readback #(
    .N(N), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (rd_en),
    .addr_i (addr),
    .flag_i (flag_q),
    .en_i   (en_q),
    .rdata_o(rdata)
  );

  evirq_irq_reg #(.N(N)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .flag_i(flag_q),
    .en_i  (en_q),
    .irq_o (irq)
  );
endmodule

// File: rtl/evirq_ctrl_chk.sv
module evirq_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hD,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'hE,
  parameter logic [DATA_W-2:0] LEVEL_MASK = 'h03
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-2:0] set_pulse,
  input logic [DATA_W-2:0] lvl_in,
  input logic              irq,
  input logic [DATA_W-2:0] flag_q,
  input logic [DATA_W-2:0] en_q
);
  localparam int unsigned N = DATA_W - 1;
  localparam logic [N-1:0] EVM = ~LEVEL_MASK;

  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (flag_q == '0 && en_q == '0 && !irq)); // R1
  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst) (|(flag_q & en_q)) |=> irq); // R2
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst) !(|(flag_q & en_q)) |=> !irq); // R2
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst) (wr_en && addr == EN_ADDR && wdata[DATA_W-1]) |=> ((en_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0]))); // R3
  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (rst) (wr_en && addr == EN_ADDR && !wdata[DATA_W-1]) |=> ((en_q & $past(wdata[N-1:0])) == '0)); // R4
  AST_EN_READ_TOP: assert property (@(posedge clk) disable iff (rst) (rd_en && addr == EN_ADDR) |=> rdata[DATA_W-1]); // R5
  AST_FLAG_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst) (wr_en && addr == FLAG_ADDR && ((wdata[N-1:0] & EVM & ~set_pulse) != '0)) |=> ((flag_q & $past(wdata[N-1:0] & EVM & ~set_pulse)) == '0)); // R7
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !rst |=> ((flag_q & LEVEL_MASK) == ($past(lvl_in) & LEVEL_MASK))); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (|(set_pulse & EVM)) |=> ((flag_q & $past(set_pulse & EVM)) == $past(set_pulse & EVM))); // R11
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rdata)); // R12
endmodule

bind evirq_ctrl evirq_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR),
  .EN_ADDR(EN_ADDR), .LEVEL_MASK(LEVEL_MASK)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .set_pulse(set_pulse), .lvl_in(lvl_in),
  .irq(irq), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/evirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evirq_ctrl_tb_top;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_PULSE = 2'd2, OP_CLR = 2'd3;
  localparam logic [3:0] A_FLAG = 4'hD, A_EN = 4'hE, A_OTHER = 4'h3;

  function automatic logic [22:0] mk(logic [1:0] op, logic [3:0] a, logic [7:0] d,
                                     logic [7:0] e, logic q);
    return {op, a, d, e, q};
  endfunction

  localparam int NV = 24;
  localparam logic [22:0] VEC [NV] = '{
    mk(OP_RD,    A_EN,   8'h00, 8'h80, 1'b0), // R1 R5
    mk(OP_RD,    A_FLAG, 8'h00, 8'h00, 1'b0), // R1 R6
    mk(OP_PULSE, A_FLAG, 8'h7C, 8'h00, 1'b0), // R8
    mk(OP_RD,    A_FLAG, 8'h00, 8'h7C, 1'b0), // R8 R6
    mk(OP_WR,    A_EN,   8'h84, 8'h00, 1'b1), // R3 R2
    mk(OP_RD,    A_EN,   8'h00, 8'h84, 1'b1), // R3 R5
    mk(OP_RD,    A_FLAG, 8'h00, 8'hFC, 1'b1), // R6
    mk(OP_WR,    A_EN,   8'h90, 8'h00, 1'b1), // R3
    mk(OP_RD,    A_EN,   8'h00, 8'h94, 1'b1), // R3
    mk(OP_WR,    A_EN,   8'h04, 8'h00, 1'b1), // R4
    mk(OP_RD,    A_EN,   8'h00, 8'h90, 1'b1), // R4
    mk(OP_WR,    A_FLAG, 8'h10, 8'h00, 1'b0), // R7 R2
    mk(OP_RD,    A_FLAG, 8'h00, 8'h6C, 1'b0), // R7 R6
    mk(OP_WR,    A_FLAG, 8'h00, 8'h00, 1'b0), // R7
    mk(OP_RD,    A_FLAG, 8'h00, 8'h6C, 1'b0), // R7
    mk(OP_PULSE, A_FLAG, 8'h03, 8'h00, 1'b0), // R8
    mk(OP_RD,    A_FLAG, 8'h00, 8'h6C, 1'b0), // R8
    mk(OP_CLR,   A_FLAG, 8'h08, 8'h00, 1'b0), // R10
    mk(OP_RD,    A_FLAG, 8'h00, 8'h64, 1'b0), // R10
    mk(OP_WR,    A_EN,   8'hFF, 8'h00, 1'b1), // R3 R2
    mk(OP_RD,    A_FLAG, 8'h00, 8'hE4, 1'b1), // R6
    mk(OP_WR,    A_EN,   8'h7F, 8'h00, 1'b0), // R4 R2
    mk(OP_RD,    A_EN,   8'h00, 8'h80, 1'b0), // R4 R5
    mk(OP_RD,    A_OTHER,8'h00, 8'h00, 1'b0)  // R12
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [6:0] set_pulse = '0, clr_req = '0, lvl_in = '0;
  logic       irq;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  evirq_ctrl dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .set_pulse(set_pulse), .clr_req(clr_req),
    .lvl_in(lvl_in), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] op, logic [3:0] a, logic [7:0] d);
    addr = a;
    case (op)
      OP_RD:    rd_en = 1'b1;
      OP_WR:    begin wr_en = 1'b1; wdata = d; end
      OP_PULSE: set_pulse = d[6:0];
      default:  clr_req = d[6:0];
    endcase
  endtask

  task automatic idle();
    rd_en = 1'b0; wr_en = 1'b0; wdata = '0; set_pulse = '0; clr_req = '0;
  endtask

  task automatic do_op(logic [1:0] op, logic [3:0] a, logic [7:0] d);
    @(negedge clk); drive(op, a, d);
    @(negedge clk); idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    check("R1 rdata after reset", rdata, 8'h00);

    for (int k = 0; k < NV; k++) begin
      do_op(VEC[k][22:21], VEC[k][20:17], VEC[k][16:9]);
      if (VEC[k][22:21] == OP_RD)
        check($sformatf("vector %0d read", k), rdata, VEC[k][8:1]);
      check($sformatf("vector %0d irq", k), {7'b0, irq}, {7'b0, VEC[k][0]});
    end

    // R12: write to an unused address leaves enable untouched, rdata held
    do_op(OP_WR, A_OTHER, 8'hFF);
    check("R12 rdata held without read", rdata, 8'h00);
    do_op(OP_RD, A_EN, 8'h00);
    check("R12 unused write ignored", rdata, 8'h80);

    // R2: irq rises exactly one cycle after the enable register changes
    @(negedge clk); drive(OP_WR, A_EN, 8'hC0);
    @(negedge clk); idle();
    check("R2 irq not yet high", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R2 irq high one cycle later", {7'b0, irq}, 8'h01);
    do_op(OP_WR, A_EN, 8'h40);

    // R9: level bit follows its input and ignores software clears
    @(negedge clk); lvl_in = 7'h01;
    do_op(OP_RD, A_FLAG, 8'h00);
    check("R9 level bit set", rdata, 8'h65);
    do_op(OP_WR, A_FLAG, 8'h01);
    do_op(OP_CLR, A_FLAG, 8'h01);
    do_op(OP_RD, A_FLAG, 8'h00);
    check("R9 level bit survives clear", rdata, 8'h65);
    @(negedge clk); lvl_in = 7'h00;
    do_op(OP_RD, A_FLAG, 8'h00);
    check("R9 level bit follows low", rdata, 8'h64);

    // R11: set pulse, flag write and clear request on bit 3 together
    @(negedge clk);
    set_pulse = 7'h08; clr_req = 7'h08; wr_en = 1'b1; addr = A_FLAG; wdata = 8'h08;
    @(negedge clk); idle();
    do_op(OP_RD, A_FLAG, 8'h00);
    check("R11 set wins over clear", rdata, 8'h6C);

    // R1: reset in mid-run
    do_op(OP_WR, A_EN, 8'hFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq cleared by reset", {7'b0, irq}, 8'h00);
    do_op(OP_RD, A_FLAG, 8'h00);
    check("R1 flags cleared by reset", rdata, 8'h00);
    do_op(OP_RD, A_EN, 8'h00);
    check("R1 enables cleared by reset", rdata, 8'h80);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule